// File: doc/BRIEF.md
# Two-Wire Supply Control Register

This block is a two-wire serial bus target that owns one 8-bit control byte for a supply section: two switched linear regulators and two high-side drivers. A bus controller writes the byte to turn outputs on and to choose output levels, and can read it back. The block samples the bus lines with its own system clock, finds START and STOP conditions, receives bytes most significant bit first, checks its 7-bit address and answers with an acknowledge by pulling the data line low.

The byte's fields drive the outputs directly. Next to the raw level codes, the block reports the level each regulator is set to, in units of 100 mV. The bus logic and all outputs work only while the active-mode input `en` is high. When `en` is low the bus is ignored and the byte is cleared. A battery over-voltage input switches both regulators off at once. The stored byte is left as it is, so the regulators come back on their own once the condition clears.

The protocol engine is a state machine with eight states. `ST_IDLE`: waiting for START. `ST_ADDR`: shifting in the address byte. `ST_AACK`: acknowledging a matching address. `ST_WDATA`: shifting in a data byte. `ST_WACK`: acknowledging a data byte. `ST_RDATA`: shifting the stored byte out. `ST_RACK`: sampling the controller's acknowledge. `ST_SKIP`: staying off the bus until the next START or STOP.

Its transitions:
- From any state: START goes to `ST_ADDR`, STOP goes to `ST_IDLE`, and `en` low goes to `ST_IDLE`.
- `ST_ADDR`, on the SCL fall after eight bits: to `ST_AACK` on an address match, to `ST_SKIP` otherwise.
- `ST_AACK`, on the next SCL fall: to `ST_RDATA` if the R/W bit is 1, to `ST_WDATA` if it is 0.
- `ST_WDATA`, on the SCL fall after eight bits: to `ST_WACK`.
- `ST_WACK`, on the next SCL fall: back to `ST_WDATA`.
- `ST_RDATA`, on the eighth SCL fall: to `ST_RACK`.
- `ST_RACK`, on the next SCL fall: back to `ST_RDATA` if the controller acknowledged, to `ST_SKIP` if it did not.

Top module: `supply_ctl_i2c`

## Requirements
- R1: The 7-bit target address is 0001000. The first byte after START carries the address in bits 7..1 and R/W in bit 0 (1 = read), so the write byte is 0x10 and the read byte is 0x11. A matching address is acknowledged. Any other address gets no acknowledge, and the bus is ignored until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START during a transfer restarts address reception. Bytes are 8 bits, most significant bit first. The target acknowledges by pulling SDA low (`sda_oe` = 1) for the ninth clock, and it only asserts `sda_oe` while SCL is low.
- R3: On a write, each data byte is stored when its eighth bit completes. Several data bytes in one transfer each overwrite the byte, so the last one wins.
- R4: On a read, the stored byte is sent most significant bit first. Another copy follows as long as the controller acknowledges. A missing acknowledge ends the read.
- R5: Field map of the byte. Bit 7 enables regulator 2 (`reg2_on`). Bits 6..4 are its level code (`reg2_code`). Bit 3 enables regulator 1 (`reg1_on`). Bit 2 selects its level (`reg1_sel`). Bit 1 enables driver 2 (`drv2_on`). Bit 0 enables driver 1 (`drv1_on`).
- R6: `reg2_dv` gives the regulator-2 level in 100 mV units. Codes 0 to 7 give 33, 50, 55, 60, 70, 75, 80 and 100. `reg1_dv` is 50 when `reg1_sel` = 0 and 85 when `reg1_sel` = 1.
- R7: While `ovp` is high, `reg1_on` and `reg2_on` are 0. The drivers and the stored byte are unchanged, and both regulators return to their stored state when `ovp` falls.
- R8: While `en` is low, `sda_oe` is 0, no address is acknowledged, all four enables are 0 and the stored byte is cleared to 0x00. After `en` rises again, the byte reads back as 0x00.
- R9: After reset the stored byte is 0x00 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Active-mode enable; low = standby |
| ovp | input | 1 | Battery over-voltage present |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| reg2_on | output | 1 | Regulator 2 enable |
| reg2_code | output | 3 | Regulator 2 level code |
| reg2_dv | output | 7 | Regulator 2 level, 100 mV units |
| reg1_on | output | 1 | Regulator 1 enable |
| reg1_sel | output | 1 | Regulator 1 level select |
| reg1_dv | output | 7 | Regulator 1 level, 100 mV units |
| drv2_on | output | 1 | High-side driver 2 enable |
| drv1_on | output | 1 | High-side driver 1 enable |

## Verification
Some properties are checked on every cycle. In standby the data line is released and every enable is off. Over-voltage keeps both regulators off. An acknowledge or data bit only starts while SCL is low. An enable output changes only while SCL is low, unless `en` changed.

Other behaviour only the bench's transfers can show. These are address matching, the bit order of written and read bytes, last-byte-wins on multi-byte writes, read continuation and termination, and repeated START. They also include the byte surviving over-voltage, the byte being cleared by standby, and the full level-code table.

// File: rtl/supply_ctl_pkg.sv
package supply_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } bus_state_t;

    localparam int CTL_W      = 8;
    localparam int F_R2_EN    = 7;
    localparam int F_R2_SEL_H = 6;
    localparam int F_R2_SEL_L = 4;
    localparam int F_R1_EN    = 3;
    localparam int F_R1_SEL   = 2;
    localparam int F_D2_EN    = 1;
    localparam int F_D1_EN    = 0;
    localparam int LVL_W      = 7;

    // Regulator-2 level in units of 100 mV for each 3-bit code
    function automatic logic [LVL_W-1:0] r2_level(input logic [2:0] code);
        logic [LVL_W-1:0] v;
        unique case (code)
            3'd0: v = 7'd33;
            3'd1: v = 7'd50;
            3'd2: v = 7'd55;
            3'd3: v = 7'd60;
            3'd4: v = 7'd70;
            3'd5: v = 7'd75;
            3'd6: v = 7'd80;
            3'd7: v = 7'd100;
            default: v = 7'd0;
        endcase
        return v;
    endfunction

    // Regulator-1 level in units of 100 mV
    function automatic logic [LVL_W-1:0] r1_level(input logic sel);
        return sel ? 7'd85 : 7'd50;
    endfunction

endpackage

// File: rtl/supply_ctl_sync.sv
module supply_ctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    // Idle bus lines are high, so the chain resets to ones
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/supply_ctl_fsm.sv
module supply_ctl_fsm
    import supply_ctl_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h08,
    parameter int         DW    = CTL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          scl_hi,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          sda_rise,
    input  logic          sda_fall,
    output logic          sda_oe,
    output logic [DW-1:0] ctrl_q
);
    localparam int CW = $clog2(DW + 1);

    bus_state_t    st, nxt;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic [DW-1:0] tx;
    logic          mack;
    logic          start_ev, stop_ev;

    assign start_ev = sda_fall & scl_hi & ~scl_rise;
    assign stop_ev  = sda_rise & scl_hi & ~scl_rise;

    always_comb begin
        nxt = st;
        if (!en)           nxt = ST_IDLE;
        else if (start_ev) nxt = ST_ADDR;
        else if (stop_ev)  nxt = ST_IDLE;
        else begin
            unique case (st)
                ST_IDLE, ST_SKIP: nxt = st;
                ST_ADDR:  if (scl_fall && cnt == CW'(DW))
                              nxt = (sh[DW-1:1] == ADDR7) ? ST_AACK : ST_SKIP;
                ST_AACK:  if (scl_fall) nxt = sh[0] ? ST_RDATA : ST_WDATA;
                ST_WDATA: if (scl_fall && cnt == CW'(DW)) nxt = ST_WACK;
                ST_WACK:  if (scl_fall) nxt = ST_WDATA;
                ST_RDATA: if (scl_fall && cnt == CW'(DW - 1)) nxt = ST_RACK;
                ST_RACK:  if (scl_fall) nxt = mack ? ST_RDATA : ST_SKIP;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Shift, count and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            mack   <= 1'b0;
            ctrl_q <= '0;
        end else if (!en) begin
            cnt    <= '0;
            sh     <= '0;
            tx     <= '0;
            mack   <= 1'b0;
            ctrl_q <= '0;
        end else if (start_ev) begin
            cnt <= '0;
        end else begin
            unique case (st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[DW-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                    end
                    if (st == ST_WDATA && scl_fall && cnt == CW'(DW))
                        ctrl_q <= sh;
                end
                ST_AACK: if (scl_fall) begin
                    cnt <= '0;
                    tx  <= ctrl_q;
                end
                ST_WACK: if (scl_fall) cnt <= '0;
                ST_RDATA: if (scl_fall) begin
                    tx  <= {tx[DW-2:0], 1'b0};
                    cnt <= cnt + 1'b1;
                end
                ST_RACK: begin
                    if (scl_rise) mack <= ~sda_lvl;
                    if (scl_fall) begin
                        tx  <= ctrl_q;
                        cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Line drive
    always_comb begin
        unique case (st)
            ST_AACK, ST_WACK: sda_oe = en;
            ST_RDATA:         sda_oe = en & ~tx[DW-1];
            default:          sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/supply_ctl_gate.sv
module supply_ctl_gate
    import supply_ctl_pkg::*;
(
    input  logic             en,
    input  logic             ovp,
    input  logic [CTL_W-1:0] ctrl,
    output logic             reg2_on,
    output logic [2:0]       reg2_code,
    output logic [LVL_W-1:0] reg2_dv,
    output logic             reg1_on,
    output logic             reg1_sel,
    output logic [LVL_W-1:0] reg1_dv,
    output logic             drv2_on,
    output logic             drv1_on
);
    logic reg_ok;
    assign reg_ok = en & ~ovp;

    assign reg2_on   = reg_ok & ctrl[F_R2_EN];
    assign reg2_code = ctrl[F_R2_SEL_H:F_R2_SEL_L];
    assign reg2_dv   = r2_level(reg2_code);
    assign reg1_on   = reg_ok & ctrl[F_R1_EN];
    assign reg1_sel  = ctrl[F_R1_SEL];
    assign reg1_dv   = r1_level(reg1_sel);
    assign drv2_on   = en & ctrl[F_D2_EN];
    assign drv1_on   = en & ctrl[F_D1_EN];
endmodule

// File: rtl/supply_ctl_i2c.sv
module supply_ctl_i2c
    import supply_ctl_pkg::*;
#(
    parameter logic [6:0] ADDR7       = 7'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ovp,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    output logic             reg2_on,
    output logic [2:0]       reg2_code,
    output logic [LVL_W-1:0] reg2_dv,
    output logic             reg1_on,
    output logic             reg1_sel,
    output logic [LVL_W-1:0] reg1_dv,
    output logic             drv2_on,
    output logic             drv1_on
);
    localparam int NLINES = 2;   // index 0: SCL, index 1: SDA

    logic [NLINES-1:0] raw_w, lvl_w, rise_w, fall_w;
    logic [CTL_W-1:0]  ctrl_w;

    assign raw_w = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_sync
        supply_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_w[g]),
            .level (lvl_w[g]),
            .rise  (rise_w[g]),
            .fall  (fall_w[g])
        );
    end

    supply_ctl_fsm #(.ADDR7(ADDR7), .DW(CTL_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .scl_hi   (lvl_w[0]),
        .scl_rise (rise_w[0]),
        .scl_fall (fall_w[0]),
        .sda_lvl  (lvl_w[1]),
        .sda_rise (rise_w[1]),
        .sda_fall (fall_w[1]),
        .sda_oe   (sda_oe),
        .ctrl_q   (ctrl_w)
    );

    supply_ctl_gate u_gate (
        .en        (en),
        .ovp       (ovp),
        .ctrl      (ctrl_w),
        .reg2_on   (reg2_on),
        .reg2_code (reg2_code),
        .reg2_dv   (reg2_dv),
        .reg1_on   (reg1_on),
        .reg1_sel  (reg1_sel),
        .reg1_dv   (reg1_dv),
        .drv2_on   (drv2_on),
        .drv1_on   (drv1_on)
    );
endmodule

// File: rtl/supply_ctl_i2c_chk.sv
module supply_ctl_i2c_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic ovp,
    input logic scl_in,
    input logic sda_oe,
    input logic reg2_on,
    input logic reg1_on,
    input logic drv2_on,
    input logic drv1_on
);
    // R8: standby releases the bus and switches everything off
    a_r8_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!sda_oe && !reg2_on && !reg1_on && !drv2_on && !drv1_on));

    // R7: over-voltage keeps both regulators off
    a_r7_ovp_off: assert property (@(posedge clk) disable iff (!rst_n)
        ovp |-> (!reg2_on && !reg1_on));

    // R2: the target starts driving the data line only while SCL is low
    a_r2_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in);

    // R3: a stored byte changes driver 1 only while SCL is low
    a_r3_drv1_update: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && ($rose(drv1_on) || $fell(drv1_on))) |-> !scl_in);

    // R3: the same for driver 2
    a_r3_drv2_update: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && ($rose(drv2_on) || $fell(drv2_on))) |-> !scl_in);
endmodule

bind supply_ctl_i2c supply_ctl_i2c_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .ovp     (ovp),
    .scl_in  (scl_in),
    .sda_oe  (sda_oe),
    .reg2_on (reg2_on),
    .reg1_on (reg1_on),
    .drv2_on (drv2_on),
    .drv1_on (drv1_on)
);

// File: tb/sim_supply_ctl_i2c.sv
module sim_supply_ctl_i2c;
    localparam int Q  = 8;   // system clocks per quarter bus bit
    localparam int NV = 8;
    localparam logic [7:0] A_WR = 8'h10;
    localparam logic [7:0] A_RD = 8'h11;
    // {ovp, data byte}
    localparam logic [8:0] VEC [NV] = '{
        9'h0_8F, 9'h0_9C, 9'h1_A3, 9'h0_B8,
        9'h0_44, 9'h1_DD, 9'h0_E1, 9'h0_F6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic ovp = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, reg2_on, reg1_on, reg1_sel, drv2_on, drv1_on;
    logic [2:0] reg2_code;
    logic [6:0] reg2_dv, reg1_dv;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    supply_ctl_i2c u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .ovp(ovp),
        .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .reg2_on(reg2_on), .reg2_code(reg2_code), .reg2_dv(reg2_dv),
        .reg1_on(reg1_on), .reg1_sel(reg1_sel), .reg1_dv(reg1_dv),
        .drv2_on(drv2_on), .drv1_on(drv1_on)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_r2(input logic [2:0] c);
        case (c)
            3'd0: return 7'd33;  3'd1: return 7'd50;
            3'd2: return 7'd55;  3'd3: return 7'd60;
            3'd4: return 7'd70;  3'd5: return 7'd75;
            3'd6: return 7'd80;  default: return 7'd100;
        endcase
    endfunction

    function automatic logic [21:0] exp_outs(input logic [7:0] b, input logic ov, input logic e);
        return {b[7] & ~ov & e, b[6:4], exp_r2(b[6:4]), b[3] & ~ov & e, b[2],
                b[2] ? 7'd85 : 7'd50, b[1] & e, b[0] & e};
    endfunction

    function automatic logic [21:0] act_outs();
        return {reg2_on, reg2_code, reg2_dv, reg1_on, reg1_sel, reg1_dv, drv2_on, drv1_on};
    endfunction

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(~give_ack);
    endtask

    task automatic do_write(input logic [7:0] ab, input logic [7:0] d, output logic aa, output logic da);
        bus_start();
        write_byte(ab, aa);
        da = 1'b0;
        if (aa) write_byte(d, da);
        bus_stop();
    endtask

    task automatic do_read(output logic aa, output logic [7:0] d);
        bus_start();
        write_byte(A_RD, aa);
        d = 8'hxx;
        if (aa) read_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic aa, da;
        logic [7:0] rd, rd2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: reset state
        chk(sda_oe == 1'b0, "R9 sda_oe after reset", 32'(sda_oe), 0);
        chk(act_outs() == exp_outs(8'h00, 1'b0, 1'b1), "R9 outputs after reset", 32'(act_outs()), 32'(exp_outs(8'h00, 1'b0, 1'b1)));
        do_read(aa, rd);
        chk(aa && rd == 8'h00, "R9 readback after reset", {23'd0, aa, rd}, {23'd0, 1'b1, 8'h00});

        // Vector table: R1 R3 R5 R6 R7 R4
        for (int v = 0; v < NV; v++) begin
            ovp = VEC[v][8];
            do_write(A_WR, VEC[v][7:0], aa, da);
            chk(aa, "R1 address ack", 32'(aa), 1);
            chk(da, "R3 data ack", 32'(da), 1);
            repeat (4) @(negedge clk);
            chk(act_outs() == exp_outs(VEC[v][7:0], VEC[v][8], 1'b1), "R5 R6 R7 field outputs",
                32'(act_outs()), 32'(exp_outs(VEC[v][7:0], VEC[v][8], 1'b1)));
            do_read(aa, rd);
            chk(rd == VEC[v][7:0], "R4 readback", 32'(rd), 32'(VEC[v][7:0]));
        end
        ovp = 1'b0;

        // R1: wrong address is not acknowledged and changes nothing
        do_write(8'h12, 8'hFF, aa, da);
        chk(!aa, "R1 foreign address nack", 32'(aa), 0);
        repeat (4) @(negedge clk);
        chk(act_outs() == exp_outs(8'hF6, 1'b0, 1'b1), "R1 outputs after foreign address", 32'(act_outs()), 32'(exp_outs(8'hF6, 1'b0, 1'b1)));
        do_read(aa, rd);
        chk(rd == 8'hF6, "R1 byte kept after foreign address", 32'(rd), 32'hF6);

        // R3: multi-byte write, last byte wins
        bus_start();
        write_byte(A_WR, aa);
        write_byte(8'h11, da);
        write_byte(8'h2A, da);
        bus_stop();
        chk(da, "R3 second data ack", 32'(da), 1);
        do_read(aa, rd);
        chk(rd == 8'h2A, "R3 last byte wins", 32'(rd), 32'h2A);

        // R4: read continues while acknowledged
        bus_start();
        write_byte(A_RD, aa);
        read_byte(1'b1, rd);
        read_byte(1'b0, rd2);
        bus_stop();
        chk(rd == 8'h2A && rd2 == 8'h2A, "R4 repeated read", {16'd0, rd, rd2}, 32'h2A2A);
        chk(sda_oe == 1'b0, "R4 bus released after nack", 32'(sda_oe), 0);

        // R2: repeated START switches from write to read
        bus_start();
        write_byte(A_WR, aa);
        bus_start();
        write_byte(A_RD, da);
        read_byte(1'b0, rd);
        bus_stop();
        chk(da && rd == 8'h2A, "R2 repeated start read", {23'd0, da, rd}, {23'd0, 1'b1, 8'h2A});

        // R7: over-voltage keeps the byte, recovery is automatic
        do_write(A_WR, 8'h8B, aa, da);
        ovp = 1'b1;
        repeat (3) @(negedge clk);
        chk(act_outs() == exp_outs(8'h8B, 1'b1, 1'b1), "R7 regulators off during ovp", 32'(act_outs()), 32'(exp_outs(8'h8B, 1'b1, 1'b1)));
        do_read(aa, rd);
        chk(rd == 8'h8B, "R7 byte kept during ovp", 32'(rd), 32'h8B);
        ovp = 1'b0;
        repeat (3) @(negedge clk);
        chk(act_outs() == exp_outs(8'h8B, 1'b0, 1'b1), "R7 recovery after ovp", 32'(act_outs()), 32'(exp_outs(8'h8B, 1'b0, 1'b1)));

        // R8: standby ignores the bus and clears the byte
        en = 1'b0;
        repeat (3) @(negedge clk);
        chk(act_outs() == exp_outs(8'h8B, 1'b0, 1'b0), "R8 outputs off in standby", 32'(act_outs()), 32'(exp_outs(8'h8B, 1'b0, 1'b0)));
        do_write(A_WR, 8'hFF, aa, da);
        chk(!aa, "R8 no ack in standby", 32'(aa), 0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk(act_outs() == exp_outs(8'h00, 1'b0, 1'b1), "R8 outputs after standby", 32'(act_outs()), 32'(exp_outs(8'h00, 1'b0, 1'b1)));
        do_read(aa, rd);
        chk(aa && rd == 8'h00, "R8 byte cleared by standby", {23'd0, aa, rd}, {23'd0, 1'b1, 8'h00});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule